// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low modem handshake lines: carrier detect, ring indicator, data set ready and clear to send. It brings each line into the local clock domain through a short synchronizer chain. It then publishes an 8-bit status byte in the low end of a 32-bit read word. The upper nibble of that byte gives the present logical state of each line, where 1 means the line is asserted (the pin is low). The lower nibble holds one sticky change flag per line.

The carrier, data-set-ready and clear-to-send flags catch any transition of their line. The ring flag catches only the end of a ring, which is the pin returning from low to high. Each flag stays set until software reads the word. A read is a single-cycle strobe. The read data is always present combinationally, so the strobe cycle returns the value as it stood before the clear. The clock edge that ends the strobe clears all four flags. If a fresh transition is detected in that same cycle, the transition wins and its flag stays set.

An interrupt line is the OR of the four flags, gated by an enable input. The read port and the interrupt are plain control and status pins with no valid/ready handshake. The strobe is never back-pressured, and the data is meaningful whenever it is sampled.

Top module: `modem_status_monitor`

## Requirements
- R1: While reset is held and in the cycle it releases, rd_data reads 0. The synchronizers start in the deasserted (pin high) state and all flags are clear.
- R2: rd_data bit 7 is carrier, bit 6 ring, bit 5 data set ready and bit 4 clear to send. Each bit is 1 when its pin is low. A pin change shows in these bits after exactly two rising clock edges.
- R3: rd_data bits 31:8 always read 0.
- R4: Bit 3 (carrier change) becomes 1 one clock after bit 7 changes in either direction.
- R5: Bit 1 (data-set-ready change) and bit 0 (clear-to-send change) follow the same any-transition rule for bits 5 and 4.
- R6: Bit 2 (ring trailing edge) becomes 1 one clock after bit 6 goes from 1 to 0, and never because bit 6 goes from 0 to 1.
- R7: A set flag stays 1 while no read strobe occurs, even if its line returns to its earlier level.
- R8: rd_data during a strobe cycle shows the pre-clear flags. After the rising edge at the end of that cycle, all four flags read 0 unless R9 applies.
- R9: A transition detected in the strobe cycle sets its flag after that edge regardless of the clear.
- R10: irq equals irq_en AND the OR of rd_data bits 3:0, with no added clock delay.
- R11: A pin held low through reset is seen as a change once reset releases. For carrier, data set ready and clear to send, the flag sets three edges after release. A ring pin held low gives no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_n | input | 1 | Carrier detect pin, active low, asynchronous |
| ring_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dset_rdy_n | input | 1 | Data set ready pin, active low, asynchronous |
| clr_send_n | input | 1 | Clear to send pin, active low, asynchronous |
| rd_stb | input | 1 | One-cycle read strobe; clears change flags at the next edge |
| rd_data | output | 32 | Status word (bits 7:4 line state, 3:0 change flags) |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Modem status interrupt |

## Verification
The clear-on-read and a newly detected transition can land in the same cycle. This is the case where a flag could be lost. The bench provokes it by placing the read strobe in the exact cycle after a pin change has crossed the synchronizer, but before the change flag register has taken it. A different flag is set beforehand so that one read must both clear one line and keep another. The bench judges the cycle by checking the read data during the strobe, which must show the pre-clear flags. It then checks the flags one edge later, where the new flag must be set and the old one cleared.

// File: rtl/msm_pkg.sv
package msm_pkg;
  localparam int unsigned NUM_LINES = 4;
  localparam int unsigned LINE_CTS = 0;
  localparam int unsigned LINE_DSR = 1;
  localparam int unsigned LINE_RING = 2;
  localparam int unsigned LINE_CARRIER = 3;

  typedef enum logic {
    EDGE_ANY   = 1'b0,
    EDGE_TRAIL = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/msm_sync.sv
module msm_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= din;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[k] <= RST_VAL;
      else        chain[k] <= chain[k-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/msm_change_flag.sv
module msm_change_flag
  import msm_pkg::*;
#(
  parameter edge_mode_e MODE = EDGE_ANY
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_n,
  input  logic clr,
  output logic flag
);
  logic prev_n;
  logic hit;

  if (MODE == EDGE_ANY) begin : g_any
    assign hit = level_n ^ prev_n;
  end else begin : g_trail
    // pin leaves its low (asserted) level
    assign hit = level_n & ~prev_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n <= 1'b1;
      flag   <= 1'b0;
    end else begin
      prev_n <= level_n;
      flag   <= hit | (flag & ~clr);
    end
  end
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
  import msm_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier_n,
  input  logic             ring_n,
  input  logic             dset_rdy_n,
  input  logic             clr_send_n,
  input  logic             rd_stb,
  output logic [REG_W-1:0] rd_data,
  input  logic             irq_en,
  output logic             irq
);
  localparam int unsigned STATUS_W = 2 * NUM_LINES;
  localparam int unsigned RSV_W = REG_W - STATUS_W;

  logic [NUM_LINES-1:0] pins_raw;
  logic [NUM_LINES-1:0] pins_sync;
  logic [NUM_LINES-1:0] flags;

  assign pins_raw[LINE_CARRIER] = carrier_n;
  assign pins_raw[LINE_RING]    = ring_n;
  assign pins_raw[LINE_DSR]     = dset_rdy_n;
  assign pins_raw[LINE_CTS]     = clr_send_n;

  msm_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL({NUM_LINES{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .dout (pins_sync)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam edge_mode_e MODE = (i == LINE_RING) ? EDGE_TRAIL : EDGE_ANY;
    msm_change_flag #(.MODE(MODE)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .level_n(pins_sync[i]),
      .clr    (rd_stb),
      .flag   (flags[i])
    );
  end

  assign rd_data = {{RSV_W{1'b0}}, ~pins_sync, flags};
  assign irq     = irq_en & (|flags);
endmodule

// File: rtl/msm_checker.sv
module msm_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_stb,
  input logic [31:0] rd_data,
  input logic        irq_en,
  input logic        irq
);
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:8] == 24'd0); // R3

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0]))); // R7

  AST_CARRIER_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[3]) |-> ($past(rd_data[7], 2) != $past(rd_data[7]))); // R4

  AST_DSR_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> ($past(rd_data[5], 2) != $past(rd_data[5]))); // R5

  AST_CTS_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[0]) |-> ($past(rd_data[4], 2) != $past(rd_data[4]))); // R5

  AST_RING_TRAILING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[2]) |-> ($past(rd_data[6], 2) && !$past(rd_data[6]))); // R6

  AST_IRQ_FOLLOWS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_en && (rd_data[3:0] != 4'd0))); // R10
endmodule

bind modem_status_monitor msm_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_stb (rd_stb),
  .rd_data(rd_data),
  .irq_en (irq_en),
  .irq    (irq)
);

// File: tb/modem_status_monitor_test.sv
module modem_status_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = 4'b0000; // {carrier, ring, dsr, cts} raw levels
  logic        rd_stb = 1'b0;
  logic        irq_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  modem_status_monitor uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .carrier_n (pins[3]),
    .ring_n    (pins[2]),
    .dset_rdy_n(pins[1]),
    .clr_send_n(pins[0]),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .irq_en    (irq_en),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_read();
    rd_stb = 1'b1;
    step(1);
    rd_stb = 1'b0;
  endtask

  function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] f;
    f = (a ^ b) & 4'b1011;
    f[2] = ~a[2] & b[2];
    return f;
  endfunction

  initial begin
    // R11 / R1: all pins asserted through reset
    step(3);
    chk("R1 reset value", rd_data, 32'd0);
    rst_n = 1'b1;
    chk("R1 release cycle", rd_data, 32'd0);
    step(2);
    chk("R2 sync latency, flags not yet set", rd_data, 32'h0000_00F0);
    step(1);
    chk("R11 low-at-reset lines flagged, ring not", rd_data, 32'h0000_00FB);
    clear_read();

    // Exhaustive sweep of all from/to pin patterns
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pins = 4'(a);
        step(3);
        clear_read();
        chk("R2 settled status", rd_data, {24'd0, ~4'(a), 4'd0});
        pins = 4'(b);
        step(2);
        chk("R2 status after two edges", rd_data, {24'd0, ~4'(b), 4'd0});
        step(1);
        chk("R4 R5 R6 change flags", rd_data, {24'd0, ~4'(b), exp_flags(4'(a), 4'(b))});
        chk("R3 reserved bits", {8'd0, rd_data[31:8]}, 32'd0);
        irq_en = 1'b1;
        #1;
        chk("R10 irq enabled", {31'd0, irq}, {31'd0, |exp_flags(4'(a), 4'(b))});
        irq_en = 1'b0;
        #1;
        chk("R10 irq gated off", {31'd0, irq}, 32'd0);
        rd_stb = 1'b1;
        chk("R8 strobe cycle shows pre-clear flags", rd_data,
            {24'd0, ~4'(b), exp_flags(4'(a), 4'(b))});
        step(1);
        rd_stb = 1'b0;
        chk("R8 flags cleared by read", rd_data, {24'd0, ~4'(b), 4'd0});
      end
    end

    // R7: carrier pulse that returns before any read
    pins = 4'b1111;
    step(3);
    clear_read();
    pins = 4'b0111;
    step(3);
    pins = 4'b1111;
    step(3);
    chk("R7 flag held after line returns", rd_data, 32'h0000_0008);
    step(5);
    chk("R7 flag still held without read", rd_data, 32'h0000_0008);

    // R9: read collides with a fresh carrier edge, cts flag pre-set
    clear_read();
    pins = 4'b1110;
    step(3);
    chk("R9 setup cts flag", rd_data, 32'h0000_0011);
    pins = 4'b0110;
    step(2);
    rd_stb = 1'b1;
    chk("R9 strobe cycle before new flag", rd_data, 32'h0000_0091);
    step(1);
    rd_stb = 1'b0;
    chk("R9 edge in read cycle survives clear", rd_data, 32'h0000_0098);

    // R6: ring leading edge alone gives no flag
    clear_read();
    pins = 4'b0010;
    step(4);
    chk("R6 ring leading edge not flagged", rd_data, 32'h0000_00D0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule